// File: doc/BRIEF.md
# ADC Power-Fail Threshold Comparator

This block sits between a 10-bit analog-to-digital converter and the interrupt controller. For every finished conversion it decides whether the converter interrupt is raised. Software programs two byte-wide registers over a simple peripheral bus. The mode register holds an enable bit and a polarity bit. The threshold register holds an 8-bit unsigned value.

With the enable bit clear, the block does no comparison and every conversion raises an interrupt. With the enable bit set, the block compares the upper eight bits of each result against the threshold. It raises the interrupt only when the result is at or above the threshold (polarity 0) or below it (polarity 1). Software can then sample a supply rail continuously and is interrupted only when the rail crosses a chosen level, which is a power-fail detector.

Every accepted write holds the bus for one wait cycle. The addressed register takes its new value at the end of that cycle. The mode register also accepts single-bit writes.

Top module: `pfc_top`

## Requirements
- R1: After synchronous reset, both registers read 0x00, `adc_irq` is 0 and `bus_wait` is 0.
- R2: The mode register is decoded at address 0xFF2A and the threshold register at 0xFF2B. A read (`bus_rd` high at a clock edge) loads `bus_rdata` at that edge, and `bus_rdata` holds that value until the next read.
- R3: In the mode register, bit 7 is the comparison enable and bit 6 is the polarity select. Bits 5..0 always read 0, even after a byte write of ones.
- R4: With enable = 0, every clock edge with `conv_done` high produces `adc_irq` high for exactly the following clock cycle, whatever the result value.
- R5: With enable = 1 and polarity = 0, a conversion raises `adc_irq` only if `conv_res[9:2]` >= threshold (unsigned).
- R6: With enable = 1 and polarity = 1, a conversion raises `adc_irq` only if `conv_res[9:2]` < threshold (unsigned).
- R7: Result bits 1..0 have no effect on the interrupt decision.
- R8: The comparison uses the `conv_res` value present at the same edge as `conv_done`. Later changes of `conv_res` do not affect that decision.
- R9: A write to either register address, accepted while `bus_wait` is low, drives `bus_wait` high for exactly the next clock cycle. The register changes at the end of that cycle, so a read during the wait cycle returns the old value. A write presented while `bus_wait` is high is ignored.
- R10: With `bus_bitop` = 1, a write to the mode register sets the bit at position `bus_bitpos` to `bus_wdata[0]`, and only for positions 7 and 6. Other positions leave the register unchanged. A single-bit write to the threshold register leaves it unchanged. Both kinds still insert the wait cycle.
- R11: Writes to any other address change no register and do not assert `bus_wait`. Reads from any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address for read and write |
| bus_wr | input | 1 | Write request |
| bus_bitop | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_bitpos | input | 3 | Bit position for a single-bit write |
| bus_wdata | input | 8 | Write data; bit 0 is the value for a single-bit write |
| bus_rd | input | 1 | Read request |
| conv_done | input | 1 | One-clock strobe, conversion finished |
| conv_res | input | 10 | Conversion result |
| bus_rdata | output | 8 | Registered read data |
| bus_wait | output | 1 | Bus wait, high for one cycle after an accepted write |
| adc_irq | output | 1 | Registered converter interrupt pulse |

## Verification
The bench builds the block with the default parameters: a 10-bit result, an 8-bit threshold and a 16-bit address with the two registers at 0xFF2A and 0xFF2B. These sizes make the threshold extremes reachable: 0x00, where polarity 0 always fires and polarity 1 never does, and 0xFF, which only a full-scale upper byte reaches. They also make the two discarded low result bits reachable, so results that differ only in those bits can be shown to give the same decision. The write path is exercised with byte and single-bit writes, with a read and a second write issued inside the wait cycle, and with accesses to a neighbouring unmapped address.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Which register a bus address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MODE = 2'd1,
    SEL_THR  = 2'd2
  } reg_sel_e;

  // Captured write waiting to be applied at the end of the wait cycle
  typedef struct packed {
    reg_sel_e   sel;
    logic       bitop;
    logic [2:0] pos;
    logic [7:0] data;
  } pend_wr_t;

endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
  import pfc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          THR_W     = 8,
  parameter logic [15:0] MODE_ADDR = 16'hFF2A,
  parameter logic [15:0] THR_ADDR  = 16'hFF2B,
  parameter int          EN_POS    = 7,
  parameter int          POL_POS   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_bitop,
  input  logic [2:0]        bus_bitpos,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              mode_en,
  output logic              mode_pol,
  output logic [THR_W-1:0]  thr
);

  localparam logic [2:0] EN_P  = 3'(EN_POS);
  localparam logic [2:0] POL_P = 3'(POL_POS);

  reg_sel_e              sel;
  logic                  accept;
  logic                  wait_q;
  logic [2:0]            pend_pos;
  logic [DATA_W-1:0]     pend_data;
  reg_sel_e              pend_sel;
  logic                  pend_bit;
  logic                  en_q;
  logic                  pol_q;
  logic [THR_W-1:0]      thr_q;
  logic [DATA_W-1:0]     mode_byte;
  logic [DATA_W-1:0]     rd_mux;
  logic [DATA_W-1:0]     rdata_q;

  // Address decode
  always_comb begin
    if (bus_addr == ADDR_W'(MODE_ADDR))      sel = SEL_MODE;
    else if (bus_addr == ADDR_W'(THR_ADDR))  sel = SEL_THR;
    else                                     sel = SEL_NONE;
  end

  assign accept = bus_wr && !wait_q && (sel != SEL_NONE);

  // Capture the write and raise the one-cycle wait
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q    <= 1'b0;
      pend_sel  <= SEL_NONE;
      pend_bit  <= 1'b0;
      pend_pos  <= '0;
      pend_data <= '0;
    end else if (accept) begin
      wait_q    <= 1'b1;
      pend_sel  <= sel;
      pend_bit  <= bus_bitop;
      pend_pos  <= bus_bitpos;
      pend_data <= bus_wdata;
    end else begin
      wait_q    <= 1'b0;
    end
  end

  // Apply the pending write at the end of the wait cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      pol_q <= 1'b0;
      thr_q <= '0;
    end else if (wait_q) begin
      if (pend_sel == SEL_MODE) begin
        if (pend_bit) begin
          if (pend_pos == EN_P)  en_q  <= pend_data[0];
          if (pend_pos == POL_P) pol_q <= pend_data[0];
        end else begin
          en_q  <= pend_data[EN_POS];
          pol_q <= pend_data[POL_POS];
        end
      end else if (pend_sel == SEL_THR && !pend_bit) begin
        thr_q <= pend_data[THR_W-1:0];
      end
    end
  end

  // Read path
  always_comb begin
    mode_byte          = '0;
    mode_byte[EN_POS]  = en_q;
    mode_byte[POL_POS] = pol_q;
  end

  always_comb begin
    unique case (sel)
      SEL_MODE: rd_mux = mode_byte;
      SEL_THR:  rd_mux = DATA_W'(thr_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign bus_wait  = wait_q;
  assign mode_en   = en_q;
  assign mode_pol  = pol_q;
  assign thr       = thr_q;

  // R9
  wait_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wait_q |=> !wait_q);

  // R9
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wait_q |=> $stable(thr_q));

  // R10
  thr_bitop_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_q && pend_bit) |=> $stable(thr_q));

  // R11
  no_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !wait_q && sel == SEL_NONE) |=> !wait_q);

endmodule

// File: rtl/pfc_cmp.sv
module pfc_cmp #(
  parameter int RES_W = 10,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_res,
  input  logic             cmp_en,
  input  logic             cmp_pol,
  input  logic [THR_W-1:0] thr,
  output logic             irq
);

  localparam int LSB = RES_W - THR_W;

  logic [THR_W-1:0] res_hi;
  logic             at_or_above;
  logic             hit;
  logic             irq_q;

  // Select the upper result bits; the slice exists only when widths differ
  generate
    if (LSB > 0) begin : g_slice
      assign res_hi = conv_res[RES_W-1:LSB];
    end else begin : g_full
      assign res_hi = conv_res[THR_W-1:0];
    end
  endgenerate

  assign at_or_above = (res_hi >= thr);
  assign hit         = !cmp_en || (cmp_pol ? !at_or_above : at_or_above);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= conv_done && hit;
  end

  assign irq = irq_q;

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(conv_done));

  // R4
  dis_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !cmp_en) |=> irq_q);

  // R5
  ge_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && cmp_en && !cmp_pol && (res_hi < thr)) |=> !irq_q);

  // R6
  lt_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && cmp_en && cmp_pol && (res_hi >= thr)) |=> !irq_q);

  // R4
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> !irq_q);

endmodule

// File: rtl/pfc_top.sv
module pfc_top #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          RES_W     = 10,
  parameter int          THR_W     = 8,
  parameter logic [15:0] MODE_ADDR = 16'hFF2A,
  parameter logic [15:0] THR_ADDR  = 16'hFF2B,
  parameter int          EN_POS    = 7,
  parameter int          POL_POS   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_bitop,
  input  logic [2:0]        bus_bitpos,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_res,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              adc_irq
);

  logic             mode_en;
  logic             mode_pol;
  logic [THR_W-1:0] thr;

  pfc_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .THR_W    (THR_W),
    .MODE_ADDR(MODE_ADDR),
    .THR_ADDR (THR_ADDR),
    .EN_POS   (EN_POS),
    .POL_POS  (POL_POS)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_bitop (bus_bitop),
    .bus_bitpos(bus_bitpos),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_wait  (bus_wait),
    .mode_en   (mode_en),
    .mode_pol  (mode_pol),
    .thr       (thr)
  );

  pfc_cmp #(
    .RES_W(RES_W),
    .THR_W(THR_W)
  ) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .conv_done(conv_done),
    .conv_res (conv_res),
    .cmp_en   (mode_en),
    .cmp_pol  (mode_pol),
    .thr      (thr),
    .irq      (adc_irq)
  );

endmodule

// File: tb/sim_pfc_top.sv
module sim_pfc_top;

  localparam logic [15:0] A_MODE = 16'hFF2A;
  localparam logic [15:0] A_THR  = 16'hFF2B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_bitop = 1'b0;
  logic [2:0]  bus_bitpos = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_res = '0;
  logic [7:0]  bus_rdata;
  logic        bus_wait;
  logic        adc_irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pfc_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_bitop(bus_bitop), .bus_bitpos(bus_bitpos), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .conv_done(conv_done), .conv_res(conv_res),
    .bus_rdata(bus_rdata), .bus_wait(bus_wait), .adc_irq(adc_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Byte or single-bit write; checks the wait timing (R9/R10/R11)
  task automatic write_reg(input logic [15:0] a, input logic bitop,
                           input logic [2:0] pos, input logic [7:0] d,
                           input logic exp_wait, input string req);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_bitop = bitop; bus_bitpos = pos; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_bitop = 1'b0;
    check({req, " wait during cycle"}, int'(bus_wait), int'(exp_wait));
    @(negedge clk);
    check({req, " wait released"}, int'(bus_wait), 0);
  endtask

  // One conversion; conv_res is scrambled after the strobe edge (R8)
  task automatic convert(input logic [9:0] r, input logic exp_irq, input string req);
    @(negedge clk);
    conv_done = 1'b1; conv_res = r;
    @(negedge clk);
    conv_done = 1'b0; conv_res = ~r;
    check({req, " irq"}, int'(adc_irq), int'(exp_irq));
    @(negedge clk);
    check({req, " irq one cycle"}, int'(adc_irq), 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq after reset", int'(adc_irq), 0);
    check("R1 wait after reset", int'(bus_wait), 0);
    read_reg(A_MODE, d); check("R1 R2 mode reset", int'(d), 8'h00);
    read_reg(A_THR, d);  check("R1 R2 thr reset", int'(d), 8'h00);
  endtask

  task automatic t_disabled;
    convert(10'h000, 1'b1, "R4 zero result");
    convert(10'h3FF, 1'b1, "R4 full scale");
    convert(10'h155, 1'b1, "R4 mid value");
    // back-to-back strobes
    @(negedge clk); conv_done = 1'b1; conv_res = 10'h001;
    @(negedge clk); check("R4 back-to-back first", int'(adc_irq), 1);
    @(negedge clk); conv_done = 1'b0;
    check("R4 back-to-back second", int'(adc_irq), 1);
    @(negedge clk); check("R4 back-to-back end", int'(adc_irq), 0);
  endtask

  task automatic t_mode_rw;
    logic [7:0] d;
    write_reg(A_MODE, 1'b0, 3'd0, 8'hFF, 1'b1, "R9 mode byte");
    read_reg(A_MODE, d); check("R3 low bits read zero", int'(d), 8'hC0);
    write_reg(A_MODE, 1'b0, 3'd0, 8'h3F, 1'b1, "R9 mode byte");
    read_reg(A_MODE, d); check("R3 mode cleared", int'(d), 8'h00);
  endtask

  task automatic t_ge;
    write_reg(A_MODE, 1'b0, 3'd0, 8'h80, 1'b1, "R9 mode");
    write_reg(A_THR, 1'b0, 3'd0, 8'h40, 1'b1, "R9 thr");
    convert(10'h100, 1'b1, "R5 equal fires");
    convert(10'h0FF, 1'b0, "R5 below masked");
    convert(10'h3FF, 1'b1, "R5 above fires");
    convert(10'h0FC, 1'b0, "R7 low bits 00 below");
    convert(10'h103, 1'b1, "R7 low bits 11 equal");
    write_reg(A_THR, 1'b0, 3'd0, 8'h00, 1'b1, "R9 thr");
    convert(10'h000, 1'b1, "R5 zero threshold fires");
    write_reg(A_THR, 1'b0, 3'd0, 8'hFF, 1'b1, "R9 thr");
    convert(10'h3FC, 1'b1, "R5 max threshold met");
    convert(10'h3FB, 1'b0, "R5 max threshold missed");
  endtask

  task automatic t_lt;
    write_reg(A_MODE, 1'b0, 3'd0, 8'hC0, 1'b1, "R9 mode");
    write_reg(A_THR, 1'b0, 3'd0, 8'h40, 1'b1, "R9 thr");
    convert(10'h0FF, 1'b1, "R6 below fires");
    convert(10'h100, 1'b0, "R6 equal masked");
    convert(10'h0FC, 1'b1, "R7 R6 low bits ignored");
    convert(10'h3FF, 1'b0, "R8 R6 full scale masked");
    write_reg(A_THR, 1'b0, 3'd0, 8'h00, 1'b1, "R9 thr");
    convert(10'h000, 1'b0, "R6 zero threshold never fires");
  endtask

  task automatic t_wait;
    logic [7:0] d;
    write_reg(A_THR, 1'b0, 3'd0, 8'h12, 1'b1, "R9 thr setup");
    @(negedge clk);
    bus_addr = A_THR; bus_wr = 1'b1; bus_wdata = 8'h55;
    @(negedge clk);
    // wait cycle: second write and a read presented together
    bus_wdata = 8'hAA; bus_rd = 1'b1;
    check("R9 wait high", int'(bus_wait), 1);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 read in wait returns old", int'(bus_rdata), 8'h12);
    check("R9 write in wait not accepted", int'(bus_wait), 0);
    read_reg(A_THR, d); check("R9 new value after wait", int'(d), 8'h55);
  endtask

  task automatic t_bit;
    logic [7:0] d;
    write_reg(A_MODE, 1'b0, 3'd0, 8'h00, 1'b1, "R9 mode clear");
    write_reg(A_MODE, 1'b1, 3'd7, 8'h01, 1'b1, "R10 set enable");
    read_reg(A_MODE, d); check("R10 enable bit set", int'(d), 8'h80);
    write_reg(A_MODE, 1'b1, 3'd6, 8'h01, 1'b1, "R10 set polarity");
    read_reg(A_MODE, d); check("R10 polarity bit set", int'(d), 8'hC0);
    write_reg(A_MODE, 1'b1, 3'd7, 8'hFE, 1'b1, "R10 clear enable");
    read_reg(A_MODE, d); check("R10 enable bit cleared", int'(d), 8'h40);
    write_reg(A_MODE, 1'b1, 3'd3, 8'h01, 1'b1, "R10 low position");
    read_reg(A_MODE, d); check("R10 low position ignored", int'(d), 8'h40);
    write_reg(A_THR, 1'b0, 3'd0, 8'h33, 1'b1, "R9 thr");
    write_reg(A_THR, 1'b1, 3'd0, 8'hFF, 1'b1, "R10 thr bit write");
    read_reg(A_THR, d); check("R10 thr bit write ignored", int'(d), 8'h33);
  endtask

  task automatic t_other;
    logic [7:0] d;
    write_reg(16'hFF2C, 1'b0, 3'd0, 8'hFF, 1'b0, "R11 unmapped write");
    write_reg(16'h0000, 1'b0, 3'd0, 8'h00, 1'b0, "R11 unmapped write");
    read_reg(A_MODE, d); check("R11 mode untouched", int'(d), 8'h40);
    read_reg(A_THR, d);  check("R11 thr untouched", int'(d), 8'h33);
    read_reg(16'hFF29, d); check("R11 unmapped read", int'(d), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_mode_rw();
    t_ge();
    t_lt();
    t_wait();
    t_bit();
    t_other();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule